// File: doc/BRIEF.md
# Configurable MCU Port Pin Controller

This block manages eight general-purpose pins that sit on a microcontroller's 8-bit data bus. Software reaches a small set of memory-mapped registers and chooses a role for each pin on its own. A pin can be plain I/O, with a direction bit and an output data bit. It can be an output that carries one of the low address bits. It can also be an input whose level is captured by the address strobe. The captured value is presented as a latched address.

One mode bit switches the whole port into a peripheral buffer. In that mode the port passes the MCU data bus out to the pins during a write strobe, and passes the pin levels back onto the data bus during a read strobe. This only happens while at least one of two peripheral-select inputs is active. With no select active, both sides stay in high impedance. Pad electrical behaviour is outside the block: it exports a per-pin drive-select bit and separate in, out and enable signals for each pin.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset, the data, direction, control, drive-select and mode registers are 0, every `pin_oe` bit is 0, and `pin_drv` is 0.
- R2: Register offsets on `bus_addr` are: 0 = output data, 1 = direction, 2 = control, 3 = drive select, 4 = mode, 5 = pin levels (read only), 6 and 7 = unused. A write is taken at the clock edge where `bus_sel` and `bus_wr` are both 1. When `bus_sel` is 1, `bus_rdata` shows the addressed register at once. Offsets 6 and 7 read 0, and writes to offsets 5, 6 and 7 change no register. The mode register stores only bit 7, and its other bits read 0.
- R3: A pin with control bit 0 and direction bit 1 is driven (`pin_oe`=1), and `pin_out` equals its output data bit.
- R4: A pin with control bit 0 and direction bit 0 is not driven (`pin_oe`=0, `pin_out`=0). Offset 5 reads back the current `pin_in` levels.
- R5: A pin with control bit 1 is driven with the matching bit of `mcu_addr`, whatever its direction bit.
- R6: Bit n of each configuration register governs only pin n, so different pins can use different roles at the same time.
- R7: While `addr_strobe` is 1, the address latch is transparent: its value follows `pin_in` in the same cycle.
- R8: When `addr_strobe` is 0, the latch holds the `pin_in` value sampled at the last clock edge where the strobe was 1.
- R9: Bit n of `addr_lat` shows latch bit n only when pin n has control 0 and direction 0. Otherwise that bit reads 0.
- R10: When mode bit 7 is 1, a select (`per_sel0` or `per_sel1`) is active, `per_wr` is 1 and `per_rd` is 0, all pins are driven with `dbus_in`. This overrides control and direction.
- R11: When mode bit 7 is 1, a select is active, `per_rd` is 1 and `per_wr` is 0, `dbus_oe` is 1, `dbus_out` equals `pin_in`, and no pin is driven.
- R12: In peripheral mode, the port drives neither the pins nor the data bus when no select is active, when no strobe is active, or when both strobes are active. `dbus_oe` and any `pin_oe` bit are never 1 together.
- R13: `pin_drv` equals the drive-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| mcu_addr | input | 8 | Low MCU address bits |
| addr_strobe | input | 1 | Address strobe, active high |
| per_sel0 | input | 1 | Peripheral select 0 |
| per_sel1 | input | 1 | Peripheral select 1 |
| per_wr | input | 1 | Peripheral write strobe |
| per_rd | input | 1 | Peripheral read strobe |
| dbus_in | input | 8 | MCU data bus toward the port |
| dbus_out | output | 8 | Pin data toward the MCU data bus |
| dbus_oe | output | 1 | Drive enable for the MCU data bus |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Per-pin output enable |
| pin_drv | output | 8 | Per-pin drive select |
| addr_lat | output | 8 | Latched address from input-role pins |

## Verification
The hardest case to reach is the latch hold. The pins must change after the strobe falls while the latch output stays fixed, and the masking must then be shown to follow configuration changes made long after the capture. The stimulus first sets every pin to input. It raises the strobe and changes the pins twice inside the strobe window, then drops the strobe and drives new pin values. After that it rewrites the direction and control registers so that single bits leave the input role. Peripheral mode is entered with control and direction set to all ones, so any leak of the per-pin roles into the buffer paths shows up on the pins.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int unsigned OFS_W = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA = 3'd0,
        OFS_DIR  = 3'd1,
        OFS_CTRL = 3'd2,
        OFS_DRV  = 3'd3,
        OFS_MODE = 3'd4,
        OFS_PINS = 3'd5
    } reg_ofs_e;
endpackage

// File: rtl/port_cfg_regs.sv
module port_cfg_regs
    import cfg_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [W-1:0]     bus_wdata,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     bus_rdata,
    output logic [W-1:0]     data_o,
    output logic [W-1:0]     dir_o,
    output logic [W-1:0]     ctrl_o,
    output logic [W-1:0]     drv_o,
    output logic             periph_o
);
    localparam int unsigned MODE_BIT = W - 1;

    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
        logic [W-1:0] ctrl;
        logic [W-1:0] drv;
        logic         periph;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_en;

    always_comb begin
        cfg_d = cfg_q;
        wr_en = bus_sel & bus_wr;
        if (wr_en) begin
            case (bus_addr)
                OFS_DATA: cfg_d.data   = bus_wdata;
                OFS_DIR:  cfg_d.dir    = bus_wdata;
                OFS_CTRL: cfg_d.ctrl   = bus_wdata;
                OFS_DRV:  cfg_d.drv    = bus_wdata;
                OFS_MODE: cfg_d.periph = bus_wdata[MODE_BIT];
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_DATA: bus_rdata = cfg_q.data;
                OFS_DIR:  bus_rdata = cfg_q.dir;
                OFS_CTRL: bus_rdata = cfg_q.ctrl;
                OFS_DRV:  bus_rdata = cfg_q.drv;
                OFS_MODE: bus_rdata[MODE_BIT] = cfg_q.periph;
                OFS_PINS: bus_rdata = pin_in;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign data_o   = cfg_q.data;
    assign dir_o    = cfg_q.dir;
    assign ctrl_o   = cfg_q.ctrl;
    assign drv_o    = cfg_q.drv;
    assign periph_o = cfg_q.periph;
endmodule

// File: rtl/port_addr_latch.sv
module port_addr_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] held_o,
    output logic [W-1:0] view_o
);
    typedef struct packed {
        logic [W-1:0] cap;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (strobe) begin
            lat_d.cap = pin_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign held_o = lat_q.cap;
    assign view_o = strobe ? pin_in : lat_q.cap;
endmodule

// File: rtl/port_pin_mux.sv
module port_pin_mux #(
    parameter int unsigned W = 8
) (
    input  logic         periph,
    input  logic         any_sel,
    input  logic         per_wr,
    input  logic         per_rd,
    input  logic [W-1:0] ctrl,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] data,
    input  logic [W-1:0] mcu_addr,
    input  logic [W-1:0] dbus_in,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] lat_view,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] dbus_out,
    output logic         dbus_oe,
    output logic [W-1:0] addr_lat
);
    logic buf_to_pins;
    logic buf_to_bus;

    always_comb begin
        buf_to_pins = periph & any_sel & per_wr & ~per_rd;
        buf_to_bus  = periph & any_sel & per_rd & ~per_wr;
    end

    assign dbus_oe  = buf_to_bus;
    assign dbus_out = buf_to_bus ? pin_in : '0;

    for (genvar n = 0; n < W; n++) begin : g_pin
        always_comb begin
            if (periph) begin
                pin_oe[n]  = buf_to_pins;
                pin_out[n] = buf_to_pins & dbus_in[n];
            end else if (ctrl[n]) begin
                pin_oe[n]  = 1'b1;
                pin_out[n] = mcu_addr[n];
            end else if (dir[n]) begin
                pin_oe[n]  = 1'b1;
                pin_out[n] = data[n];
            end else begin
                pin_oe[n]  = 1'b0;
                pin_out[n] = 1'b0;
            end
            addr_lat[n] = ~ctrl[n] & ~dir[n] & lat_view[n];
        end
    end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     mcu_addr,
    input  logic             addr_strobe,
    input  logic             per_sel0,
    input  logic             per_sel1,
    input  logic             per_wr,
    input  logic             per_rd,
    input  logic [W-1:0]     dbus_in,
    output logic [W-1:0]     dbus_out,
    output logic             dbus_oe,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    output logic [W-1:0]     pin_drv,
    output logic [W-1:0]     addr_lat
);
    logic [W-1:0] data_w;
    logic [W-1:0] dir_w;
    logic [W-1:0] ctrl_w;
    logic [W-1:0] drv_w;
    logic         periph_w;
    logic [W-1:0] lat_hold_w;
    logic [W-1:0] lat_view_w;
    logic         any_sel_w;

    assign any_sel_w = per_sel0 | per_sel1;

    port_cfg_regs #(.W(W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pin_in   (pin_in),
        .bus_rdata(bus_rdata),
        .data_o   (data_w),
        .dir_o    (dir_w),
        .ctrl_o   (ctrl_w),
        .drv_o    (drv_w),
        .periph_o (periph_w)
    );

    port_addr_latch #(.W(W)) i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(addr_strobe),
        .pin_in(pin_in),
        .held_o(lat_hold_w),
        .view_o(lat_view_w)
    );

    port_pin_mux #(.W(W)) i_mux (
        .periph  (periph_w),
        .any_sel (any_sel_w),
        .per_wr  (per_wr),
        .per_rd  (per_rd),
        .ctrl    (ctrl_w),
        .dir     (dir_w),
        .data    (data_w),
        .mcu_addr(mcu_addr),
        .dbus_in (dbus_in),
        .pin_in  (pin_in),
        .lat_view(lat_view_w),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .dbus_out(dbus_out),
        .dbus_oe (dbus_oe),
        .addr_lat(addr_lat)
    );

    assign pin_drv = drv_w;
endmodule

// File: rtl/cfg_port_checker.sv
module cfg_port_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic [2:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] mcu_addr,
    input logic         addr_strobe,
    input logic         per_sel0,
    input logic         per_sel1,
    input logic         per_wr,
    input logic         per_rd,
    input logic [W-1:0] dbus_in,
    input logic         dbus_oe,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_drv,
    input logic [W-1:0] ctrl_q,
    input logic         periph_q,
    input logic [W-1:0] lat_q
);
    // R1: register outputs stay cleared while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (pin_oe == '0 && pin_drv == '0);
        end
    end

    // R12: buffer never drives both directions together
    p_one_way_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbus_oe && (pin_oe != '0)));

    // R12: no select in peripheral mode keeps both sides released
    p_nosel_hiz_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_q && !per_sel0 && !per_sel1) |-> (pin_oe == '0 && !dbus_oe));

    // R5: address-out pins are driven with the MCU address bits
    p_addr_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_q |-> (((pin_oe & ctrl_q) == ctrl_q) &&
                       ((pin_out & ctrl_q) == (mcu_addr & ctrl_q))));

    // R10: peripheral write passes the data bus to every pin
    p_per_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_q && (per_sel0 || per_sel1) && per_wr && !per_rd)
            |-> (pin_oe == '1 && pin_out == dbus_in));

    // R8: latch is frozen while the strobe is low
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe |=> $stable(lat_q));

    // R13: a drive-select write appears on pin_drv next cycle
    p_drv_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 3'd3) |=> (pin_drv == $past(bus_wdata)));
endmodule

bind cfg_port_ctrl cfg_port_checker #(.W(W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .mcu_addr   (mcu_addr),
    .addr_strobe(addr_strobe),
    .per_sel0   (per_sel0),
    .per_sel1   (per_sel1),
    .per_wr     (per_wr),
    .per_rd     (per_rd),
    .dbus_in    (dbus_in),
    .dbus_oe    (dbus_oe),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pin_drv    (pin_drv),
    .ctrl_q     (ctrl_w),
    .periph_q   (periph_w),
    .lat_q      (lat_hold_w)
);

// File: tb/test_cfg_port_ctrl.sv
module test_cfg_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] mcu_addr = '0;
    logic       addr_strobe = 1'b0;
    logic       per_sel0 = 1'b0;
    logic       per_sel1 = 1'b0;
    logic       per_wr = 1'b0;
    logic       per_rd = 1'b0;
    logic [7:0] dbus_in = '0;
    logic [7:0] dbus_out;
    logic       dbus_oe;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] pin_drv;
    logic [7:0] addr_lat;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_port_ctrl i_cfg_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mcu_addr(mcu_addr), .addr_strobe(addr_strobe),
        .per_sel0(per_sel0), .per_sel1(per_sel1), .per_wr(per_wr), .per_rd(per_rd),
        .dbus_in(dbus_in), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_drv(pin_drv), .addr_lat(addr_lat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] ofs, input logic [7:0] val);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ofs; bus_wdata = val;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] ofs, output logic [7:0] val);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ofs;
        #1 val = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int o = 0; o < 5; o++) begin
            reg_rd(3'(o), v);
            chk($sformatf("R1 reg %0d after reset", o), v, 0);
        end
        chk("R1 pin_oe after reset", pin_oe, 0);
        chk("R1 pin_drv after reset", pin_drv, 0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        reg_wr(3'd0, 8'h5A); reg_rd(3'd0, v); chk("R2 data readback", v, 8'h5A);
        reg_wr(3'd1, 8'h00); reg_rd(3'd1, v); chk("R2 dir readback", v, 8'h00);
        reg_wr(3'd3, 8'hC3); reg_rd(3'd3, v); chk("R2 drive readback", v, 8'hC3);
        chk("R13 pin_drv follows drive reg", pin_drv, 8'hC3);
        reg_wr(3'd4, 8'h7F); reg_rd(3'd4, v); chk("R2 mode keeps only bit 7", v, 8'h00);
        reg_wr(3'd6, 8'hFF); reg_rd(3'd6, v); chk("R2 offset 6 reads zero", v, 8'h00);
        reg_wr(3'd7, 8'hFF); reg_rd(3'd7, v); chk("R2 offset 7 reads zero", v, 8'h00);
        reg_wr(3'd5, 8'hFF);
        reg_rd(3'd0, v); chk("R2 data intact after ignored writes", v, 8'h5A);
        reg_rd(3'd3, v); chk("R2 drive intact after ignored writes", v, 8'hC3);
        chk("R2 pins undriven after ignored writes", pin_oe, 8'h00);
        reg_wr(3'd3, 8'h0F); chk("R13 pin_drv after rewrite", pin_drv, 8'h0F);
    endtask

    task automatic t_mcu_io;
        logic [7:0] v;
        reg_wr(3'd0, 8'hA6); reg_wr(3'd1, 8'hFF);
        #1;
        chk("R3 all outputs enabled", pin_oe, 8'hFF);
        chk("R3 outputs carry data", pin_out, 8'hA6);
        reg_wr(3'd1, 8'h00);
        @(negedge clk); pin_in = 8'h3D;
        #1;
        chk("R4 inputs undriven", pin_oe, 8'h00);
        chk("R4 input pin_out zero", pin_out, 8'h00);
        reg_rd(3'd5, v); chk("R4 pin level readback", v, 8'h3D);
    endtask

    task automatic t_addr_out;
        reg_wr(3'd1, 8'h00); reg_wr(3'd2, 8'hFF);
        @(negedge clk); mcu_addr = 8'h96;
        #1;
        chk("R5 address-out enabled dir 0", pin_oe, 8'hFF);
        chk("R5 address-out value", pin_out, 8'h96);
        reg_wr(3'd1, 8'hFF);
        @(negedge clk); mcu_addr = 8'h31;
        #1;
        chk("R5 address-out ignores dir", pin_out, 8'h31);
    endtask

    task automatic t_mix;
        // pins 7..4 address-out, 3..2 output, 1..0 input
        reg_wr(3'd2, 8'hF0); reg_wr(3'd1, 8'h0C); reg_wr(3'd0, 8'hFF);
        @(negedge clk); mcu_addr = 8'hA5; pin_in = 8'hFF;
        #1;
        chk("R6 mixed pin_oe", pin_oe, 8'hFC);
        chk("R6 mixed pin_out", pin_out, 8'hAC);
        reg_wr(3'd0, 8'h00);
        chk("R6 data change only touches outputs", pin_out, 8'hA0);
    endtask

    task automatic t_latch;
        reg_wr(3'd2, 8'h00); reg_wr(3'd1, 8'h00);
        @(negedge clk); addr_strobe = 1'b1; pin_in = 8'hA5;
        #1 chk("R7 transparent first value", addr_lat, 8'hA5);
        pin_in = 8'h3C;
        #1 chk("R7 transparent follows pins", addr_lat, 8'h3C);
        @(negedge clk); addr_strobe = 1'b0; pin_in = 8'hFF;
        #1 chk("R8 holds after strobe falls", addr_lat, 8'h3C);
        repeat (3) @(negedge clk);
        pin_in = 8'h00;
        #1 chk("R8 still held later", addr_lat, 8'h3C);
        reg_wr(3'd1, 8'h0F);
        chk("R9 output pins masked", addr_lat, 8'h30);
        reg_wr(3'd1, 8'h00); reg_wr(3'd2, 8'h04);
        chk("R9 address-out pin masked", addr_lat, 8'h38);
        reg_wr(3'd2, 8'h00);
        chk("R9 full view restored", addr_lat, 8'h3C);
    endtask

    task automatic t_periph;
        logic [7:0] v;
        reg_wr(3'd2, 8'hFF); reg_wr(3'd1, 8'hFF);
        reg_wr(3'd4, 8'hFF); reg_rd(3'd4, v); chk("R2 mode bit 7 readback", v, 8'h80);
        #1;
        chk("R12 no select pins released", pin_oe, 8'h00);
        chk("R12 no select bus released", dbus_oe, 1'b0);
        @(negedge clk); per_sel0 = 1'b1;
        #1 chk("R12 select without strobe idle", pin_oe, 8'h00);
        per_wr = 1'b1; dbus_in = 8'h5A;
        #1;
        chk("R10 write drives all pins", pin_oe, 8'hFF);
        chk("R10 write passes bus", pin_out, 8'h5A);
        chk("R12 bus released on write", dbus_oe, 1'b0);
        per_wr = 1'b0; per_rd = 1'b1; pin_in = 8'hC3;
        #1;
        chk("R11 read enables bus", dbus_oe, 1'b1);
        chk("R11 read returns pins", dbus_out, 8'hC3);
        chk("R11 pins released on read", pin_oe, 8'h00);
        per_wr = 1'b1;
        #1;
        chk("R12 both strobes bus off", dbus_oe, 1'b0);
        chk("R12 both strobes pins off", pin_oe, 8'h00);
        per_wr = 1'b0; per_sel0 = 1'b0;
        #1 chk("R12 read without select", dbus_oe, 1'b0);
        per_rd = 1'b0; per_wr = 1'b1; per_sel1 = 1'b1; dbus_in = 8'h81;
        #1 chk("R10 select 1 also enables", pin_out, 8'h81);
        per_sel1 = 1'b0;
        #1 chk("R12 write without select", pin_oe, 8'h00);
        per_wr = 1'b0;
        reg_wr(3'd4, 8'h00);
        @(negedge clk); mcu_addr = 8'h44;
        #1 chk("R5 roles return after mode off", pin_out, 8'h44);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_mcu_io();
        t_addr_out();
        t_mix();
        t_latch();
        t_periph();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule